// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pair

This block models two 8-bit microcontroller I/O ports whose pins have no direction register. Each pin is set by a single output latch bit. A 0 pulls the pin low. A 1 releases the pin to its pull-up, or leaves it floating where there is no pull-up, so the outside world can drive it and the core can read it. The CPU side is a one-cycle register interface. A select picks port A or port B. A write strobe loads the selected latch. A read returns either the synchronised pin levels or, on a read-modify-write access, the latch contents.

Port A has eight pins. Its two lowest pins have no internal pull-up, because they double as the comparator's positive and negative inputs. Port B has seven usable pins. Its bit 6 is not a pin: it reads as the synchronised result of the on-chip comparator. Port B pins also serve the alternate functions. Each has an alternate-function output that is ANDed with its latch bit. The synchronised levels of bits 0, 2 to 3 and 4 to 5 are passed on as serial receive, the two external interrupt inputs and the two timer count inputs. All pin and comparator inputs cross a two-flop synchroniser before any use.

Top module: `qport_pair`

## Requirements
- R1: After reset both latches hold all ones. No pin drives low. Pull-ups are enabled on port A bits 2 to 7 and on port B bits 0 to 5 and 7.
- R2: A write with cpuSel=0 loads cpuWrData into the port A latch at that clock edge. From then on, drvLowA[i] equals the inverse of the latch bit.
- R3: pullEnA bits 0 and 1 are always 0. For bits 2 to 7, pullEnA[i] equals the port A latch bit.
- R4: A write with cpuSel=1 loads the port B latch. For every bit except 6, drvLowB[i] is 1 exactly when the AND of latch bit i and altOutB[i] is 0. pullEnB[i] is the inverse of drvLowB[i].
- R5: Port B bit 6 never drives low and never has a pull-up. Writes to that bit, and altOutB[6], have no effect on it. A read-modify-write read returns 1 in that position.
- R6: A read with cpuRmw=0 returns pin levels through two flops. A level applied before clock edge k appears on cpuRdData after edge k+1 and not after edge k. With cpuSel=1, bit 6 returns the comparator result, delayed in the same way.
- R7: A read with cpuRmw=1 returns the latch of the selected port, whatever the pin levels are.
- R8: altRxd is the synchronised port B bit 0. altInt[1:0] is the synchronised port B bits 3:2. altTmr[1:0] is the synchronised port B bits 5:4.
- R9: A latch keeps its value in any cycle without a write to its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | Write strobe for the selected latch |
| cpuSel | input | 1 | Port select: 0 is port A, 1 is port B |
| cpuRmw | input | 1 | Read selects latch contents instead of pin levels |
| cpuWrData | input | 8 | Data to load into the latch |
| cpuRdData | output | 8 | Read data for the selected port |
| pinInA | input | 8 | Sampled pad levels of port A |
| pinInB | input | 8 | Sampled pad levels of port B (bit 6 unused) |
| cmpResult | input | 1 | Comparator result |
| altOutB | input | 8 | Alternate-function outputs for port B; 1 when unused |
| drvLowA | output | 8 | Port A drive-low enables |
| pullEnA | output | 8 | Port A pull-up enables |
| drvLowB | output | 8 | Port B drive-low enables |
| pullEnB | output | 8 | Port B pull-up enables |
| altRxd | output | 1 | Synchronised serial receive input |
| altInt | output | 2 | Synchronised external interrupt inputs |
| altTmr | output | 2 | Synchronised timer count inputs |

## Verification
The assertions assume that cpuSel is a clean 0 or 1 in every cycle where cpuWrEn is high. They also assume that reset is held for at least one edge, so the latches and synchroniser stages start from their all-ones values. The bench drives every input at the falling edge, so nothing changes near a rising edge. It holds each pin pattern for at least two rising edges before it samples a read, matching the synchroniser depth. It tests the 1-edge point only to confirm that the old value is still shown there.

// File: rtl/qport_pkg.sv
package qport_pkg;
  localparam int PORT_W = 8;

  typedef struct packed {
    logic wrA;
    logic wrB;
    logic useLatch;
    logic selB;
  } portStrobe_t;
endpackage

// File: rtl/qport_ctrl.sv
module qport_ctrl
  import qport_pkg::*;
(
  input  logic        cpuWrEn,
  input  logic        cpuSel,
  input  logic        cpuRmw,
  output portStrobe_t strobe
);
  always_comb begin
    strobe.wrA      = cpuWrEn && !cpuSel;
    strobe.wrB      = cpuWrEn && cpuSel;
    strobe.useLatch = cpuRmw;
    strobe.selB     = cpuSel;
  end
endmodule

// File: rtl/qport_datapath.sv
module qport_datapath
  import qport_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [W-1:0] PULL_MASK_A = 8'hFC,
  parameter int CMP_BIT     = 6
)(
  input  logic         clk,
  input  logic         rstN,
  input  portStrobe_t  strobe,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  input  logic [W-1:0] pinInA,
  input  logic [W-1:0] pinInB,
  input  logic         cmpResult,
  input  logic [W-1:0] altOutB,
  output logic [W-1:0] drvLowA,
  output logic [W-1:0] pullEnA,
  output logic [W-1:0] drvLowB,
  output logic [W-1:0] pullEnB,
  output logic         altRxd,
  output logic [1:0]   altInt,
  output logic [1:0]   altTmr
);
  localparam int RAW_W = 2 * W + 1;
  localparam logic [W-1:0] CMP_MASK = W'(1) << CMP_BIT;

  logic [W-1:0] latchA, latchB;
  logic [SYNC_STAGES-1:0][RAW_W-1:0] syncChain;
  logic [RAW_W-1:0] syncOut;
  logic [W-1:0] syncA, syncB, readB;
  logic syncCmp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchA <= '1;
      latchB <= '1;
    end else begin
      if (strobe.wrA) latchA <= wrData;
      if (strobe.wrB) latchB <= wrData | CMP_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], {cmpResult, pinInB, pinInA}};
  end

  assign syncOut = syncChain[SYNC_STAGES-1];
  assign syncA   = syncOut[W-1:0];
  assign syncB   = syncOut[2*W-1:W];
  assign syncCmp = syncOut[2*W];

  assign drvLowA = ~latchA;
  assign pullEnA = latchA & PULL_MASK_A;

  for (genvar i = 0; i < W; i++) begin : g_portB
    if (i == CMP_BIT) begin : g_cmp
      assign drvLowB[i] = 1'b0;
      assign pullEnB[i] = 1'b0;
      assign readB[i]   = syncCmp;
    end else begin : g_pin
      logic release_;
      assign release_   = latchB[i] & altOutB[i];
      assign drvLowB[i] = ~release_;
      assign pullEnB[i] = release_;
      assign readB[i]   = syncB[i];
    end
  end

  always_comb begin
    if (strobe.selB) rdData = strobe.useLatch ? latchB : readB;
    else             rdData = strobe.useLatch ? latchA : syncA;
  end

  assign altRxd = syncB[0];
  assign altInt = syncB[3:2];
  assign altTmr = syncB[5:4];

  // R2
  wrA_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrA |=> (drvLowA == ~$past(wrData)));
  // R4
  wrB_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrB |=> ((latchB & ~CMP_MASK) == ($past(wrData) & ~CMP_MASK)));
  // R9
  holdA_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrA |=> $stable(latchA));
  // R9
  holdB_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrB |=> $stable(latchB));
  // R3
  noPullLow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullEnA & ~PULL_MASK_A) == '0);
  // R5
  cmpBitIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !drvLowB[CMP_BIT] && !pullEnB[CMP_BIT]);
  // R4
  noFight_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((drvLowA & pullEnA) == '0) && ((drvLowB & pullEnB) == '0));
  // R2
  oneWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrA, strobe.wrB}));
endmodule

// File: rtl/qport_pair.sv
module qport_pair
  import qport_pkg::*;
#(
  parameter int W           = PORT_W,
  parameter int SYNC_STAGES = 2
)(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuWrEn,
  input  logic         cpuSel,
  input  logic         cpuRmw,
  input  logic [W-1:0] cpuWrData,
  output logic [W-1:0] cpuRdData,
  input  logic [W-1:0] pinInA,
  input  logic [W-1:0] pinInB,
  input  logic         cmpResult,
  input  logic [W-1:0] altOutB,
  output logic [W-1:0] drvLowA,
  output logic [W-1:0] pullEnA,
  output logic [W-1:0] drvLowB,
  output logic [W-1:0] pullEnB,
  output logic         altRxd,
  output logic [1:0]   altInt,
  output logic [1:0]   altTmr
);
  portStrobe_t strobe;

  qport_ctrl u_ctrl (
    .cpuWrEn(cpuWrEn),
    .cpuSel (cpuSel),
    .cpuRmw (cpuRmw),
    .strobe (strobe)
  );

  qport_datapath #(
    .W(W), .SYNC_STAGES(SYNC_STAGES), .PULL_MASK_A(W'(8'hFC)), .CMP_BIT(6)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(cpuWrData), .rdData(cpuRdData),
    .pinInA(pinInA), .pinInB(pinInB), .cmpResult(cmpResult), .altOutB(altOutB),
    .drvLowA(drvLowA), .pullEnA(pullEnA), .drvLowB(drvLowB), .pullEnB(pullEnB),
    .altRxd(altRxd), .altInt(altInt), .altTmr(altTmr)
  );
endmodule

// File: tb/sim_qport_pair.sv
`timescale 1ns/1ps
module sim_qport_pair;
  logic clk = 0;
  logic rstN = 0;
  logic cpuWrEn = 0, cpuSel = 0, cpuRmw = 0;
  logic [7:0] cpuWrData = 0;
  logic [7:0] cpuRdData;
  logic [7:0] pinInA = 8'hFF, pinInB = 8'hFF, altOutB = 8'hFF;
  logic cmpResult = 1;
  logic [7:0] drvLowA, pullEnA, drvLowB, pullEnB;
  logic altRxd;
  logic [1:0] altInt, altTmr;
  int nRun = 0, nFail = 0;

  always #4 clk = ~clk;

  qport_pair u0 (.*);

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writePort(input logic sel, input logic [7:0] d);
    @(negedge clk); cpuWrEn = 1; cpuSel = sel; cpuWrData = d;
    @(negedge clk); cpuWrEn = 0;
  endtask

  task automatic readPort(input logic sel, input logic rmw, output logic [7:0] d);
    @(negedge clk); cpuSel = sel; cpuRmw = rmw; #1 d = cpuRdData;
  endtask

  task automatic testReset();
    logic [7:0] d;
    readPort(0, 1, d); check("R1", "latch A", d, 8'hFF);
    readPort(1, 1, d); check("R1", "latch B", d, 8'hFF);
    check("R1", "drvLowA", drvLowA, 8'h00);
    check("R1", "drvLowB", drvLowB, 8'h00);
    check("R1", "pullEnA", pullEnA, 8'hFC);
    check("R1", "pullEnB", pullEnB, 8'hBF);
  endtask

  task automatic testPortA();
    logic [7:0] pats [3] = '{8'h00, 8'hA5, 8'h3C};
    foreach (pats[k]) begin
      writePort(0, pats[k]);
      check("R2", "drvLowA", drvLowA, ~pats[k]);
      check("R3", "pullEnA", pullEnA, pats[k] & 8'hFC);
    end
    writePort(0, 8'hFF);
    check("R3", "pullEnA low bits", pullEnA, 8'hFC);
  endtask

  task automatic testPortB();
    writePort(1, 8'h5A);
    check("R4", "drvLowB", drvLowB, 8'hA5 & 8'hBF);
    check("R4", "pullEnB", pullEnB, 8'h5A & 8'hBF);
    writePort(1, 8'hFF);
    @(negedge clk); altOutB = 8'b1011_1101;
    #1 check("R4", "drvLowB alt", drvLowB, 8'b0000_0010);
    check("R4", "pullEnB alt", pullEnB, 8'b1011_1101);
    @(negedge clk); altOutB = 8'hFF;
  endtask

  task automatic testCmpBit();
    logic [7:0] d;
    writePort(1, 8'h00);
    check("R5", "drvLowB bit6", {7'd0, drvLowB[6]}, 8'h00);
    check("R5", "pullEnB bit6", {7'd0, pullEnB[6]}, 8'h00);
    readPort(1, 1, d); check("R5", "rmw bit6", d, 8'h40);
    @(negedge clk); altOutB = 8'h00;
    #1 check("R5", "alt bit6 no effect", {7'd0, drvLowB[6]}, 8'h00);
    @(negedge clk); altOutB = 8'hFF;
    writePort(1, 8'hFF);
  endtask

  task automatic testPinRead();
    logic [7:0] d;
    @(negedge clk); pinInA = 8'h69; cpuSel = 0; cpuRmw = 0;
    @(posedge clk); @(negedge clk); #1 d = cpuRdData;
    check("R6", "A after 1 edge", d, 8'hFF);
    @(posedge clk); @(negedge clk); #1 d = cpuRdData;
    check("R6", "A after 2 edges", d, 8'h69);
    @(negedge clk); pinInB = 8'h00; cmpResult = 1; cpuSel = 1;
    @(posedge clk); @(posedge clk); @(negedge clk); #1 d = cpuRdData;
    check("R6", "B with cmp=1", d, 8'h40);
    @(negedge clk); pinInB = 8'hFF; cmpResult = 0;
    @(posedge clk); @(posedge clk); @(negedge clk); #1 d = cpuRdData;
    check("R6", "B with cmp=0", d, 8'hBF);
  endtask

  task automatic testRmw();
    logic [7:0] d;
    writePort(0, 8'hC3);
    @(negedge clk); pinInA = 8'h0F;
    repeat (3) @(posedge clk);
    readPort(0, 1, d); check("R7", "rmw A", d, 8'hC3);
    readPort(0, 0, d); check("R7", "pin A differs", d, 8'h0F);
    writePort(1, 8'h12);
    readPort(1, 1, d); check("R7", "rmw B", d, 8'h52);
  endtask

  task automatic testAlt();
    @(negedge clk); pinInB = 8'b0010_1001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8", "altRxd", {7'd0, altRxd}, 8'h01);
    check("R8", "altInt", {6'd0, altInt}, 8'h02);
    check("R8", "altTmr", {6'd0, altTmr}, 8'h02);
    @(negedge clk); pinInB = 8'b0001_0110;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8", "altRxd 0", {7'd0, altRxd}, 8'h00);
    check("R8", "altInt 1", {6'd0, altInt}, 8'h01);
    check("R8", "altTmr 1", {6'd0, altTmr}, 8'h01);
  endtask

  task automatic testHold();
    logic [7:0] d;
    writePort(0, 8'h81);
    writePort(1, 8'h24);
    repeat (4) @(posedge clk);
    readPort(0, 1, d); check("R9", "A held after B write", d, 8'h81);
    @(negedge clk); cpuWrEn = 0; cpuWrData = 8'h00;
    repeat (3) @(posedge clk);
    readPort(1, 1, d); check("R9", "B held", d, 8'h64);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    testReset();
    testPortA();
    testPortB();
    testCmpBit();
    testPinRead();
    testRmw();
    testAlt();
    testHold();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule